// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. Its lines are grouped into banks of equal width. Each bank has two 32-bit registers on a simple byte-addressed read/write bus. The value register holds the level a line drives when it is an output. The direction register picks input or output for each line. The block drives an output value and an output enable for every line, and it reads back pin levels through a two-flop synchronizer.

Bank registers sit at eight-byte steps starting at offset 0x08. The sixteen bytes from 0x90 to 0x9F are kept for an interrupt block that lives elsewhere. Every bank whose base would fall at or above 0x90 is therefore moved up by 0x10. An access that falls in that window raises a flag so the surrounding logic can route it to the other block. Inside this block such an access does nothing.

Top module: `gpio_port_regs`

## Requirements
- R1: For a bank n whose base (n+1)*8 is below 0x90, the value register sits at byte address (n+1)*8 and the direction register at (n+1)*8+4. A write to either one takes effect on the pads at the clock edge that accepts it.
- R2: When (n+1)*8 is 0x90 or higher, both registers of bank n move up by 0x10. With the defaults, bank 17 has its value register at 0xA0 and bank 19 has its direction register at 0xB4.
- R3: A bus access to an address from 0x90 to 0x9F sets holeHit in the same cycle. A write there changes no pad output. A read there returns 0.
- R4: A direction bit of 1 makes the line an input, so padOe is 0. A direction bit of 0 makes it an output, so padOe is 1. padOut always carries the stored value bit, whatever the direction.
- R5: A read of a value register returns, for each line, the synchronized pin level when the line is an input and the stored value when it is an output.
- R6: Pin levels pass through two flops. A read accepted at the same edge where a new pin level is first sampled returns the old level. A read accepted two edges later returns the new level.
- R7: Line i belongs to bank i / LINES_PER_BANK at bit position i % LINES_PER_BANK. The block has ceil(NUM_LINES / LINES_PER_BANK) banks.
- R8: These bits read as 0 and ignore writes: bits at or above LINES_PER_BANK, and the bits of the last bank that have no line. With the defaults, the last bank keeps only bits 3:0.
- R9: After reset every value bit is 0 and every implemented direction bit is 1. So padOe and padOut are all 0, and busRdata is 0.
- R10: An access to an offset that holds no register reads as 0 and changes nothing. This covers offsets below 0x08, offsets that are not word aligned, and offsets past the last bank.
- R11: busRdata is registered. It takes a new value on the clock edge that accepts a read and holds that value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid the cycle after the read |
| holeHit | output | 1 | Access falls in the interrupt register window |
| padIn | input | NUM_LINES | Asynchronous pin levels |
| padOut | output | NUM_LINES | Output value per line |
| padOe | output | NUM_LINES | Output enable per line, 1 when the line drives |

## Verification
Directed writes at the lowest bank, at the last bank below the hole, at the first and last banks above it, and into the hole itself show whether the address shift is applied, whether it is applied too early, or whether it is left out. Pin patterns that differ from the stored values, read back in input and in output direction, show which source the value read-back selects. A pin step followed by reads one and three edges later sets the synchronizer depth. Random mixes of value writes, direction writes and pin changes under a fixed seed are compared against a bench model of every bank. This catches wrong line-to-bank mapping and masking errors on the partial last bank.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  localparam int unsigned HOLE_LO   = 32'h90;
  localparam int unsigned HOLE_HI   = 32'h9F;
  localparam int unsigned HOLE_SKIP = 32'h10;
  localparam int unsigned BANK_STEP = 8;
  localparam int unsigned DIR_OFS   = 4;
  localparam int          IDX_W     = 8;

  // Strobes from the decode to the register datapath
  typedef struct packed {
    logic             wrData;
    logic             wrDir;
    logic             rdEn;
    logic             rdDir;
    logic             rdMiss;
    logic [IDX_W-1:0] bankIdx;
  } portStrobe_t;

  // Byte address of a bank's value register, moved past the interrupt window
  function automatic int unsigned bankBaseAddr(input int unsigned bank);
    int unsigned base;
    base = (bank + 1) * BANK_STEP;
    if (base >= HOLE_LO) base = base + HOLE_SKIP;
    return base;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/gpio_port_decode.sv
`timescale 1ns/1ps
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobe_t       strobe,
  output logic              holeHit
);

  logic [NUM_BANKS-1:0] dataHit;
  logic [NUM_BANKS-1:0] dirHit;
  logic                 mapped;
  logic                 isRead;
  logic                 isWrite;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    localparam int unsigned BASE = bankBaseAddr(b);
    assign dataHit[b] = (busAddr == ADDR_W'(BASE));
    assign dirHit[b]  = (busAddr == ADDR_W'(BASE + DIR_OFS));
  end

  assign mapped  = (|dataHit) || (|dirHit);
  assign isRead  = busSel && !busWrite;
  assign isWrite = busSel && busWrite;

  always_comb begin
    strobe         = '0;
    strobe.wrData  = isWrite && (|dataHit);
    strobe.wrDir   = isWrite && (|dirHit);
    strobe.rdEn    = isRead && mapped;
    strobe.rdDir   = |dirHit;
    strobe.rdMiss  = isRead && !mapped;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dataHit[b] || dirHit[b]) strobe.bankIdx = IDX_W'(b);
    end
  end

  assign holeHit = busSel &&
                   (busAddr >= ADDR_W'(HOLE_LO)) &&
                   (busAddr <= ADDR_W'(HOLE_HI));

endmodule

// File: rtl/gpio_port_datapath.sv
`timescale 1ns/1ps
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES      = 156,
  parameter int LINES_PER_BANK = 8,
  parameter int NUM_BANKS      = 20,
  parameter int DATA_W         = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  portStrobe_t               strobe,
  input  logic [LINES_PER_BANK-1:0] wrBits,
  input  logic [NUM_LINES-1:0]      pinSync,
  output logic [NUM_LINES-1:0]      padOut,
  output logic [NUM_LINES-1:0]      padOe,
  output logic [DATA_W-1:0]         busRdata
);

  localparam int LPB = LINES_PER_BANK;
  localparam int TOT = NUM_BANKS * LPB;

  logic [TOT-1:0] dataFlat;
  logic [TOT-1:0] dirFlat;
  logic [TOT-1:0] viewFlat;
  logic [TOT-1:0] pinPad;
  logic [LPB-1:0] rdSel;

  assign pinPad = TOT'(pinSync);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int REM  = NUM_LINES - b * LPB;
    localparam int IMPL = (REM >= LPB) ? LPB : REM;
    localparam logic [LPB-1:0] MASK =
      (IMPL >= LPB) ? {LPB{1'b1}} : LPB'((64'd1 << IMPL) - 64'd1);

    logic [LPB-1:0] dataQ;
    logic [LPB-1:0] dirQ;
    logic           selMe;

    assign selMe = (strobe.bankIdx == IDX_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ <= '0;
        dirQ  <= MASK;
      end else begin
        if (strobe.wrData && selMe) dataQ <= wrBits & MASK;
        if (strobe.wrDir && selMe)  dirQ  <= wrBits & MASK;
      end
    end

    assign dataFlat[b*LPB +: LPB] = dataQ;
    assign dirFlat[b*LPB +: LPB]  = dirQ;
    assign viewFlat[b*LPB +: LPB] = (dirQ & pinPad[b*LPB +: LPB]) |
                                    (~dirQ & dataQ);
  end

  assign padOut = dataFlat[NUM_LINES-1:0];
  assign padOe  = ~dirFlat[NUM_LINES-1:0];

  always_comb begin
    rdSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.bankIdx == IDX_W'(b)) begin
        rdSel = strobe.rdDir ? dirFlat[b*LPB +: LPB] : viewFlat[b*LPB +: LPB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      busRdata <= DATA_W'(rdSel);
    end else if (strobe.rdMiss) begin
      busRdata <= '0;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES      = 156,
  parameter int LINES_PER_BANK = 8,
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 holeHit,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  localparam int NUM_BANKS = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK;

  portStrobe_t          strobe;
  logic [NUM_LINES-1:0] pinSync;

  gpio_port_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe),
    .holeHit  (holeHit)
  );

  gpio_pin_sync #(
    .WIDTH (NUM_LINES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (pinSync)
  );

  gpio_port_datapath #(
    .NUM_LINES      (NUM_LINES),
    .LINES_PER_BANK (LINES_PER_BANK),
    .NUM_BANKS      (NUM_BANKS),
    .DATA_W         (DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrBits   (busWdata[LINES_PER_BANK-1:0]),
    .pinSync  (pinSync),
    .padOut   (padOut),
    .padOe    (padOe),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/gpio_port_regs_chk.sv
`timescale 1ns/1ps
module gpio_port_regs_chk #(
  parameter int NUM_LINES = 156,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 holeHit,
  input logic [NUM_LINES-1:0] padOut,
  input logic [NUM_LINES-1:0] padOe
);

  logic inHole;
  assign inHole = (busAddr >= ADDR_W'(8'h90)) && (busAddr <= ADDR_W'(8'h9F));

  p_hole_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && inHole) |-> holeHit);

  p_hole_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && inHole) |=> ($stable(padOut) && $stable(padOe)));

  p_hole_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && inHole) |=> (busRdata == '0));

  p_misaligned_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && (busAddr[1:0] != 2'b00)) |=> (busRdata == '0));

  p_pads_only_on_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> ($stable(padOut) && $stable(padOe)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> $stable(busRdata));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .holeHit  (holeHit),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;

  localparam int NL  = 156;
  localparam int LPB = 8;
  localparam int NB  = 20;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          holeHit;
  logic [NL-1:0] padIn = '0;
  logic [NL-1:0] padOut;
  logic [NL-1:0] padOe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [LPB-1:0] mData [NB];
  logic [LPB-1:0] mDir  [NB];

  always #2.5 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .holeHit(holeHit), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int unsigned baseOf(int b);
    int unsigned a;
    a = (b + 1) * 8;
    if (a >= 32'h90) a = a + 32'h10;
    return a;
  endfunction

  function automatic logic [LPB-1:0] implMask(int b);
    int rem;
    rem = NL - b * LPB;
    if (rem >= LPB) return '1;
    return LPB'((1 << rem) - 1);
  endfunction

  function automatic logic [DW-1:0] expRead(int b, bit isDir);
    logic [NB*LPB-1:0] pp;
    logic [LPB-1:0]    pins;
    pp = (NB*LPB)'(padIn);
    pins = pp[b*LPB +: LPB];
    if (isDir) return DW'(mDir[b]);
    return DW'(((mDir[b] & pins) | (~mDir[b] & mData[b])) & implMask(b));
  endfunction

  function automatic logic [NL-1:0] expOut();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = mData[i / LPB][i % LPB];
    return v;
  endfunction

  function automatic logic [NL-1:0] expOe();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = ~mDir[i / LPB][i % LPB];
    return v;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkPads(string req);
    checks++;
    if (padOut !== expOut() || padOe !== expOe()) begin
      errors++;
      $display("FAIL %s actual out=%h oe=%h expected out=%h oe=%h",
               req, padOut, padOe, expOut(), expOe());
    end
  endtask

  task automatic doWrite(int unsigned a, logic [DW-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(int unsigned a, output logic [DW-1:0] r);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = AW'(a);
    @(negedge clk);
    busSel = 1'b0;
    r = busRdata;
  endtask

  task automatic modelWrite(int b, bit isDir, logic [DW-1:0] d);
    doWrite(baseOf(b) + (isDir ? 4 : 0), d);
    if (isDir) mDir[b] = d[LPB-1:0] & implMask(b);
    else       mData[b] = d[LPB-1:0] & implMask(b);
  endtask

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] held;
    void'($urandom(32'h5EED));
    for (int b = 0; b < NB; b++) begin
      mData[b] = '0;
      mDir[b]  = implMask(b);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 busRdata", busRdata, '0);
    checkPads("R9 pads after reset");
    check("R9 padOe zero", DW'(|padOe), '0);
    doRead(baseOf(0) + 4, r);  check("R9 dir bank0", r, 32'hFF);
    doRead(baseOf(19) + 4, r); check("R9 dir last bank", r, 32'h0F);

    // R1 / R4 bank 0 at 0x08 / 0x0C
    modelWrite(0, 0, 32'hA5);
    modelWrite(0, 1, 32'h0F);
    check("R1 padOut bank0", DW'(padOut[7:0]), 32'hA5);
    check("R4 padOe bank0", DW'(padOe[7:0]), 32'hF0);
    checkPads("R4 pads bank0");
    doRead(32'h0C, r); check("R1 dir read 0x0C", r, 32'h0F);

    // R7 line 13 is bank 1 bit 5
    modelWrite(1, 0, 32'h20);
    modelWrite(1, 1, 32'hDF);
    check("R7 line13 out", DW'(padOut[13]), 1);
    check("R7 line13 oe", DW'(padOe[15:8]), 32'h20);

    // R1 last bank below hole, R2 banks above it
    modelWrite(16, 0, 32'h3C);
    modelWrite(16, 1, 32'h00);
    check("R1 bank16 at 0x88", DW'(padOut[135:128]), 32'h3C);
    doWrite(32'hA0, 32'h81); mData[17] = 8'h81;
    doWrite(32'hA4, 32'h00); mDir[17] = 8'h00;
    check("R2 bank17 at 0xA0", DW'(padOut[143:136]), 32'h81);
    check("R2 bank17 oe", DW'(padOe[143:136]), 32'hFF);
    doWrite(32'hB4, 32'h00); mDir[19] = 8'h00;
    doWrite(32'hB0, 32'hFF); mData[19] = 8'h0F;
    check("R2 bank19 at 0xB0", DW'(padOut[155:152]), 32'hF);
    checkPads("R2 pads");

    // R3 interrupt window
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h90; busWdata = 32'hFF;
    #1 check("R3 holeHit on 0x90", DW'(holeHit), 1);
    @(negedge clk);
    busAddr = 8'h9C; busWdata = 32'h00;
    #1 check("R3 holeHit on 0x9C", DW'(holeHit), 1);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    #1 check("R3 holeHit idle", DW'(holeHit), 0);
    checkPads("R3 hole write no effect");
    doRead(32'h94, r); check("R3 hole read zero", r, 0);
    doRead(baseOf(17), r); check("R3 bank17 intact", r, 32'h81);

    // R8 unimplemented bits
    modelWrite(3, 1, 32'h0);
    modelWrite(3, 0, 32'hFFFFFFFF);
    doRead(baseOf(3), r); check("R8 upper bits zero", r, 32'hFF);
    doRead(baseOf(19), r); check("R8 partial last bank", r, 32'h0F);
    doRead(baseOf(19) + 4, r); check("R8 partial dir", r, 32'h00);

    // R10 unmapped offsets
    doWrite(32'h00, 32'hFF);
    doWrite(32'h04, 32'hFF);
    doWrite(32'h09, 32'hFF);
    doWrite(32'hB8, 32'hFF);
    checkPads("R10 unmapped write no effect");
    doRead(32'h04, r); check("R10 read 0x04", r, 0);
    doRead(32'h0D, r); check("R10 read misaligned", r, 0);
    doRead(32'hBC, r); check("R10 read past end", r, 0);

    // R5 input vs output read source
    modelWrite(4, 1, 32'hFF);
    modelWrite(5, 1, 32'h00);
    modelWrite(5, 0, 32'h5A);
    modelWrite(6, 1, 32'hF0);
    modelWrite(6, 0, 32'h0F);
    @(negedge clk);
    padIn[39:32] = 8'hC3; padIn[47:40] = 8'hFF; padIn[55:48] = 8'hA5;
    repeat (3) @(negedge clk);
    doRead(baseOf(4), r); check("R5 input bank pins", r, 32'hC3);
    doRead(baseOf(5), r); check("R5 output bank stored", r, 32'h5A);
    doRead(baseOf(6), r); check("R5 mixed bank", r, 32'hAF);

    // R6 synchronizer depth
    modelWrite(2, 1, 32'hFF);
    @(negedge clk);
    padIn[23:16] = 8'h00;
    repeat (3) @(negedge clk);
    padIn[23:16] = 8'h3C;
    busSel = 1'b1; busWrite = 1'b0; busAddr = AW'(baseOf(2));
    @(negedge clk);
    busSel = 1'b0;
    check("R6 first edge old level", busRdata, 32'h00);
    doRead(baseOf(2), r); check("R6 third edge new level", r, 32'h3C);

    // R11 read data hold
    held = r;
    repeat (3) @(negedge clk);
    check("R11 hold idle", busRdata, held);
    modelWrite(2, 0, 32'h11);
    check("R11 hold over write", busRdata, held);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      int b;
      op = int'($urandom % 3);
      b  = int'($urandom % NB);
      if (op == 0) modelWrite(b, 0, $urandom);
      else if (op == 1) modelWrite(b, 1, $urandom);
      else begin
        @(negedge clk);
        for (int k = 0; k < NL; k++) padIn[k] = 1'($urandom % 2);
        repeat (3) @(negedge clk);
      end
      checkPads("R4 R7 random pads");
      b = int'($urandom % NB);
      op = int'($urandom % 2);
      doRead(baseOf(b) + (op == 1 ? 4 : 0), r);
      check(op == 1 ? "R1 random dir read" : "R5 random data read",
            r, expRead(b, op == 1));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule